// File: doc/BRIEF.md
# Host Interrupt Status and Mask Unit

This block gathers up to sixteen internal interrupt sources into one interrupt line toward a host processor. Each source is a level signal. A low-to-high transition on a source sets a sticky bit in a status vector. The host sees each status bit that is not blocked by a per-bit mask. A registered pin reports whether any unblocked status bit is set. A configuration register enables that pin and picks its active level.

The host reaches the block over a small register bus. The bus offers one cycle read and write strobes, a 3-bit word address, and 16-bit data. Read data is combinational and valid in the cycle the read strobe is high. Any side effect of an access takes hold at the clock edge that ends that cycle. The host can use the mask in three ways: write all of it, set chosen bits, or clear chosen bits. It can inspect the status in two ways: a read that leaves the bits in place, or a read that empties the vector. It can also retire chosen status bits by writing an acknowledge word.

The bit assignments are as follows:
- bit 0: receive buffer 0 data
- bit 1: transmit data
- bit 2: transmit transfer
- bit 3: receive buffer 1 data
- bit 4: receive transfer
- bits 5 and 6: event mailbox
- bit 7: wake
- bits 8 and 9: debug trace
- bit 10: command complete
- bit 14: initialization complete

The `PRESENT` parameter (default 0x47FF) lists the wired bits.

Top module: `hirq_unit`

## Requirements
- R1: After reset the mask reads 0x0001, both status views read 0x0000, the configuration word reads 0x0000, and `irq_o` is 0.
- R2: A rising edge on `src_i[i]` for a wired bit sets status bit i at the clock edge that samples it. A source that stays high sets the bit only once: after the bit is cleared, it stays clear until the source falls and rises again.
- R3: Address 0 is the mask. A write stores `bus_wdata_i`, and a read returns the mask. A 1 in a mask bit blocks that status bit from the pin.
- R4: A write to address 1 sets every mask bit whose data bit is 1. All other mask bits are unchanged.
- R5: A write to address 2 clears every mask bit whose data bit is 1. All other mask bits are unchanged.
- R6: A read of address 3 returns the status vector and leaves it unchanged.
- R7: A read of address 4 returns the status vector and clears every bit of it at the end of that cycle.
- R8: A write to address 5 clears every status bit whose data bit is 1. Zero data bits have no effect. The change shows in both status views.
- R9: A rising edge sampled in the same cycle as a clearing read (address 4) or an acknowledge (address 5) leaves its status bit set.
- R10: Status bits whose `PRESENT` bit is 0 always read 0, whatever their source does.
- R11: Address 6 is the configuration word: bit 0 enables the pin and bit 1 selects active-low. `irq_o` is a register. At each edge it loads the active level when the pin is enabled and (status AND NOT mask) is nonzero. Otherwise it loads the inactive level. The inputs to that decision are the values held before the edge.
- R12: Address 7 reads as 0. A write to address 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Interrupt source levels |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid while the read strobe is high |
| irq_o | output | 1 | Host interrupt pin |

## Verification
The bench drives sources that rise in the same cycle as a clearing read or an acknowledge. A design that applies the clear after the set would lose those events, and the following non-destructive read would be missing bits. It holds a source high across an acknowledge to catch a design that re-latches levels instead of edges. It also toggles unwired sources to expose status bits that should never appear. Random traffic switches the polarity and the enable and mixes the set, clear and full mask writes. This checks that the pin comes one edge after the status it reports: a pin that is combinational, or that lags by two edges, fails the per-cycle comparison.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

  localparam int unsigned SRC_W  = 16;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CFG_W  = 2;

  typedef logic [SRC_W-1:0] vec_t;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK   = 3'd0,
    A_MSET   = 3'd1,
    A_MCLR   = 3'd2,
    A_PEEK   = 3'd3,
    A_TAKE   = 3'd4,
    A_ACK    = 3'd5,
    A_CFG    = 3'd6,
    A_NONE   = 3'd7
  } reg_sel_e;

  // edge of a wired source
  function automatic vec_t f_rise(vec_t lvl, vec_t prev, vec_t present);
    return lvl & ~prev & present;
  endfunction

  // clears first, new events win
  function automatic vec_t f_status_next(vec_t cur, vec_t rise, vec_t clr);
    return (cur & ~clr) | rise;
  endfunction

  function automatic vec_t f_mask_next(vec_t cur, logic wr_all, logic wr_set,
                                       logic wr_clr, vec_t data);
    vec_t n;
    n = cur;
    if (wr_all) n = data;
    if (wr_set) n = cur | data;
    if (wr_clr) n = cur & ~data;
    return n;
  endfunction

  // registered pin value
  function automatic logic f_pin(logic en, logic low, vec_t status, vec_t mask);
    return (en & (|(status & ~mask))) ^ low;
  endfunction

endpackage

// File: rtl/hirq_edge.sv
module hirq_edge
  import hirq_pkg::*;
#(
  parameter vec_t PRESENT = 16'h47FF
) (
  input  logic clk,
  input  logic rst_n,
  input  vec_t src_i,
  output vec_t rise_o
);

  vec_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  assign rise_o = f_rise(src_i, prev_q, PRESENT);

  p_rise_is_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_o & prev_q) == '0));

endmodule

// File: rtl/hirq_status.sv
module hirq_status
  import hirq_pkg::*;
#(
  parameter vec_t PRESENT = 16'h47FF
) (
  input  logic clk,
  input  logic rst_n,
  input  vec_t rise_i,
  input  logic take_i,
  input  logic ack_wr_i,
  input  vec_t ack_bits_i,
  output vec_t status_o
);

  vec_t clr_bits;
  vec_t status_nxt;
  vec_t status_q;

  assign clr_bits   = take_i ? '1 : (ack_wr_i ? ack_bits_i : '0);
  assign status_nxt = f_status_next(status_q, rise_i, clr_bits);

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    if (PRESENT[i]) begin : g_wired
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q[i] <= 1'b0;
        else        status_q[i] <= status_nxt[i];
      end
    end else begin : g_open
      assign status_q[i] = 1'b0;
    end
  end

  assign status_o = status_q;

  p_keep_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((status_o & $past(rise_i)) == $past(rise_i)));

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr_i && !take_i) |=> ((status_o & $past(ack_bits_i & ~rise_i)) == '0));

  p_take_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> ((status_o & ~$past(rise_i)) == '0));

  p_peek_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !ack_wr_i) |=> ((status_o & $past(status_o)) == $past(status_o)));

  p_open_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o & ~PRESENT) == '0));

endmodule

// File: rtl/hirq_mask.sv
module hirq_mask
  import hirq_pkg::*;
#(
  parameter vec_t MASK_RST = 16'h0001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_all_i,
  input  logic wr_set_i,
  input  logic wr_clr_i,
  input  vec_t data_i,
  output vec_t mask_o
);

  vec_t mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= MASK_RST;
    else        mask_q <= f_mask_next(mask_q, wr_all_i, wr_set_i, wr_clr_i, data_i);
  end

  assign mask_o = mask_q;

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set_i |=> ((mask_o & $past(data_i)) == $past(data_i)
                  && (mask_o & ~$past(data_i)) == ($past(mask_o) & ~$past(data_i))));

  p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_i |=> ((mask_o & $past(data_i)) == '0
                  && (mask_o & ~$past(data_i)) == ($past(mask_o) & ~$past(data_i))));

  p_idle_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_all_i && !wr_set_i && !wr_clr_i) |=> $stable(mask_o));

  p_one_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_all_i, wr_set_i, wr_clr_i}) <= 1);

endmodule

// File: rtl/hirq_regs.sv
module hirq_regs
  import hirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  vec_t              wdata_i,
  input  vec_t              mask_i,
  input  vec_t              status_i,
  output logic              mask_wr_o,
  output logic              mask_set_o,
  output logic              mask_clr_o,
  output logic              take_o,
  output logic              ack_wr_o,
  output logic              pin_en_o,
  output logic              pin_low_o,
  output vec_t              rdata_o
);

  reg_sel_e sel;
  logic [CFG_W-1:0] cfg_q;

  assign sel = reg_sel_e'(addr_i);

  assign mask_wr_o  = wr_i && sel == A_MASK;
  assign mask_set_o = wr_i && sel == A_MSET;
  assign mask_clr_o = wr_i && sel == A_MCLR;
  assign ack_wr_o   = wr_i && sel == A_ACK;
  assign take_o     = rd_i && sel == A_TAKE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cfg_q <= '0;
    else if (wr_i && sel == A_CFG) cfg_q <= wdata_i[CFG_W-1:0];
  end

  assign pin_en_o  = cfg_q[0];
  assign pin_low_o = cfg_q[1];

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel)
        A_MASK:         rdata_o = mask_i;
        A_PEEK, A_TAKE: rdata_o = status_i;
        A_CFG:          rdata_o = {{(SRC_W-CFG_W){1'b0}}, cfg_q};
        default:        rdata_o = '0;
      endcase
    end
  end

  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && sel == A_CFG) |=> $stable(cfg_q));

endmodule

// File: rtl/hirq_unit.sv
module hirq_unit
  import hirq_pkg::*;
#(
  parameter vec_t PRESENT  = 16'h47FF,
  parameter vec_t MASK_RST = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       src_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       bus_rdata_o,
  output logic              irq_o
);

  vec_t rise;
  vec_t status;
  vec_t mask;
  logic mask_wr, mask_set, mask_clr, take, ack_wr;
  logic pin_en, pin_low;
  logic irq_q;

  hirq_edge #(.PRESENT(PRESENT)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise));

  hirq_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .rd_i(bus_rd_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .mask_i(mask), .status_i(status),
    .mask_wr_o(mask_wr), .mask_set_o(mask_set), .mask_clr_o(mask_clr),
    .take_o(take), .ack_wr_o(ack_wr),
    .pin_en_o(pin_en), .pin_low_o(pin_low),
    .rdata_o(bus_rdata_o));

  hirq_status #(.PRESENT(PRESENT)) u_status (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .take_i(take),
    .ack_wr_i(ack_wr), .ack_bits_i(bus_wdata_i), .status_o(status));

  hirq_mask #(.MASK_RST(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_all_i(mask_wr), .wr_set_i(mask_set),
    .wr_clr_i(mask_clr), .data_i(bus_wdata_i), .mask_o(mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= f_pin(pin_en, pin_low, status, mask);
  end

  assign irq_o = irq_q;

  p_pin_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |=> (irq_o == $past(pin_low)));

  p_pin_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en && (|(status & ~mask))) |=> (irq_o != $past(pin_low)));

  p_pin_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~mask) == '0) |=> (irq_o == $past(pin_low)));

endmodule

// File: tb/hirq_unit_tb_top.sv
`timescale 1ns/100ps
module hirq_unit_tb_top;

  localparam logic [15:0] WIRED = 16'h47FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int total = 0, bad = 0;

  // reference state
  logic [15:0] m_prev = '0, m_stat = '0, m_mask = 16'h0001;
  logic        m_en = 1'b0, m_low = 1'b0, m_irq = 1'b0;

  always #2.5 clk = ~clk;

  hirq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

  function automatic logic [15:0] exp_read(logic [2:0] a);
    case (a)
      3'd0:       return m_mask;
      3'd3, 3'd4: return m_stat;
      3'd6:       return {14'd0, m_low, m_en};
      default:    return 16'h0000;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle; called just after a falling edge
  task automatic tick(logic [15:0] s, logic r, logic w, logic [2:0] a,
                      logic [15:0] d, string tag);
    logic [15:0] rise, clr;
    src = s; rd = r; wr = w; addr = a; wdata = d;
    #1;
    if (r) check(tag, rdata, exp_read(a));
    check("R11 pin", {15'd0, irq}, {15'd0, m_irq});
    rise = s & ~m_prev & WIRED;
    clr  = (r && a == 3'd4) ? 16'hFFFF : ((w && a == 3'd5) ? d : 16'h0000);
    m_irq  = ((m_en && ((m_stat & ~m_mask) != 0)) ? 1'b1 : 1'b0) ^ m_low;
    m_prev = s;
    m_stat = (m_stat & ~clr) | rise;
    if (w) begin
      case (a)
        3'd0: m_mask = d;
        3'd1: m_mask = m_mask | d;
        3'd2: m_mask = m_mask & ~d;
        3'd6: begin m_en = d[0]; m_low = d[1]; end
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] s;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    tick(16'h0, 1, 0, 3'd0, 16'h0, "R1 mask reset");
    tick(16'h0, 1, 0, 3'd3, 16'h0, "R1 status reset");
    tick(16'h0, 1, 0, 3'd4, 16'h0, "R1 take reset");
    tick(16'h0, 1, 0, 3'd6, 16'h0, "R1 cfg reset");
    // R11 enable, R3 open mask
    tick(16'h0, 0, 1, 3'd6, 16'h0001, "R11");
    tick(16'h0, 0, 1, 3'd0, 16'h0000, "R3");
    tick(16'h0, 1, 0, 3'd0, 16'h0, "R3 mask readback");
    // R2 edge sets bit, level holds only once
    tick(16'h0004, 0, 0, 3'd0, 16'h0, "R2");
    tick(16'h0004, 1, 0, 3'd3, 16'h0, "R2 edge latched");
    tick(16'h0004, 0, 1, 3'd5, 16'h0004, "R8 ack");
    tick(16'h0004, 1, 0, 3'd3, 16'h0, "R2 held level not relatched");
    tick(16'h0004, 1, 0, 3'd3, 16'h0, "R6 peek again unchanged");
    // R10 unwired bits
    tick(16'hB804, 0, 0, 3'd0, 16'h0, "R10");
    tick(16'h0000, 1, 0, 3'd3, 16'h0, "R10 open bits stay zero");
    // R9 event during take and during ack
    tick(16'h0001, 0, 0, 3'd0, 16'h0, "R9");
    tick(16'h0003, 1, 0, 3'd4, 16'h0, "R7 take with event");
    tick(16'h0003, 1, 0, 3'd3, 16'h0, "R9 event kept after take");
    tick(16'h0013, 0, 1, 3'd5, 16'h0012, "R9 ack with event");
    tick(16'h0013, 1, 0, 3'd3, 16'h0, "R9 event kept after ack");
    // R4 R5 aliases
    tick(16'h0, 0, 1, 3'd1, 16'h0410, "R4");
    tick(16'h0, 1, 0, 3'd0, 16'h0, "R4 set alias");
    tick(16'h0, 0, 1, 3'd2, 16'h0011, "R5");
    tick(16'h0, 1, 0, 3'd0, 16'h0, "R5 clear alias");
    // R12 hole address
    tick(16'h0, 0, 1, 3'd7, 16'hFFFF, "R12");
    tick(16'h0, 1, 0, 3'd7, 16'h0, "R12 hole reads zero");
    tick(16'h0, 1, 0, 3'd0, 16'h0, "R12 mask untouched");
    // R11 active low
    tick(16'h0, 0, 1, 3'd6, 16'h0003, "R11");
    tick(16'h0, 1, 0, 3'd6, 16'h0, "R11 cfg readback");
    tick(16'h0, 1, 0, 3'd4, 16'h0, "R7 drain");
    tick(16'h0, 1, 0, 3'd3, 16'h0, "R7 emptied");
    // random traffic
    s = '0;
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [2:0] a;
      s = s ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      op = int'($urandom % 10);
      a  = 3'($urandom);
      if (op < 4)      tick(s, 0, 0, a, 16'h0, "R6");
      else if (op < 7) tick(s, 1, 0, a, 16'h0, "R6 R7 R3 random read");
      else             tick(s, 0, 1, a, 16'($urandom), "R8 random write");
    end
    finish_run();
  end

endmodule